// File: doc/BRIEF.md
# Atomic Read-Modify-Write Execute Unit

This unit performs a single atomic memory operation for a 64-bit core. It accepts an operation code, an access width of 32 or 64 bits, an address, the second source operand and the two ordering flags. It then reads the target location, combines the loaded value with the operand in a small ALU, and writes the combined value back. It signals completion with a one-cycle pulse that carries either the value destined for the destination register or a fault cause.

Operands are widened before they reach the ALU. For 32-bit accesses both the operand and the loaded value are zero-extended for the two unsigned min/max operations. For every other operation they are sign-extended. The destination value is always the loaded data, sign-extended from bit 31 for 32-bit accesses. A misaligned address, an undefined width or opcode, or an error response on either memory phase ends the operation with a fault. In that case the destination is not written.

The memory side is a request/response port. A request is held until a response arrives in the same or a later cycle, and the response carries an error flag. Read and write data are right-aligned on the data bus.

Top module: `amo_unit`

## Requirements
- R1: Opcodes 0..8 select, in this order, swap, add, xor, and, or, signed min, signed max, unsigned min and unsigned max. The value written to memory is that function of the extended operand and the extended loaded value.
- R2: For width code 2 (32-bit), operand bits 31..0 and read-data bits 31..0 are zero-extended for opcodes 7 and 8 and sign-extended otherwise. Read-data bits 63..32 are ignored. For width code 3 (64-bit), both values are used unchanged.
- R3: A 32-bit write presents only result bits 31..0 on the write data, with the upper bits zero, so only the addressed 32-bit location changes.
- R4: The destination value is read data bits 31..0 sign-extended for width code 2, and the full read data for width code 3, whatever the opcode.
- R5: An address not aligned to the access width ends with fault cause 4 in the cycle after start, and no memory request is made.
- R6: Width code 0 or 1, or an opcode above 8, ends with fault cause 2 in the cycle after start, and no memory request is made.
- R7: An error response to the read ends with fault cause 7 one cycle later. No write is issued and memory is unchanged.
- R8: An error response to the write ends with fault cause 7 one cycle later. The destination write enable rises only after a successful write.
- R9: The read carries acquire = aq and release = aq AND rl. The write carries acquire = aq AND rl and release = rl.
- R10: The done pulse lasts exactly one cycle. When the memory answers at once, a successful operation completes three cycles after start is taken.
- R11: After reset, done, fault, destination write enable and memory request are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin an operation (taken when idle) |
| op_i | input | 4 | Operation code |
| width_i | input | 2 | Log2 of access size in bytes |
| addr_i | input | 64 | Target address |
| rs2_i | input | 64 | Second source operand |
| aq_i | input | 1 | Acquire ordering flag |
| rl_i | input | 1 | Release ordering flag |
| mem_req_o | output | 1 | Memory request, held until response |
| mem_we_o | output | 1 | Request is a write |
| mem_addr_o | output | 64 | Request address |
| mem_size_o | output | 2 | Request size code |
| mem_wdata_o | output | 64 | Write data, right-aligned |
| mem_aq_o | output | 1 | Acquire flag of this request |
| mem_rl_o | output | 1 | Release flag of this request |
| mem_rvalid_i | input | 1 | Response valid |
| mem_rdata_i | input | 64 | Read data, right-aligned |
| mem_err_i | input | 1 | Response carries an error |
| done_o | output | 1 | Operation finished (one-cycle pulse) |
| fault_o | output | 1 | Operation finished with a fault |
| cause_o | output | 8 | Fault cause code |
| rd_we_o | output | 1 | Destination register write enable |
| rd_data_o | output | 64 | Destination register value |

## Verification
A sequencer stuck in or skipping a phase shows within a few cycles. It appears as a wrong completion latency, as a write request with no read before it, or as a done pulse wider than one cycle. A wrong extension choice or ALU selection shows at once, either in the memory contents left by the write or in the upper half of the destination value. The bench sweeps every opcode over both widths against operand pairs chosen at the sign and carry boundaries. These include mixed-half 32-bit patterns, where signed and unsigned ordering disagree. It then injects errors on each phase separately.

// File: rtl/amo_pkg.sv
package amo_pkg;
  typedef enum logic [3:0] {
    OP_SWAP = 4'd0, OP_ADD = 4'd1, OP_XOR = 4'd2, OP_AND = 4'd3, OP_OR = 4'd4,
    OP_MIN = 4'd5, OP_MAX = 4'd6, OP_MINU = 4'd7, OP_MAXU = 4'd8
  } amo_op_e;

  typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_D = 2'd3} amo_size_e;

  typedef enum logic [2:0] {ST_IDLE, ST_READ, ST_WRITE, ST_DONE, ST_FAULT} amo_state_e;

  localparam int CAUSE_W = 8;
  localparam logic [CAUSE_W-1:0] CAUSE_NONE     = 8'd0;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL  = 8'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_MISALIGN = 8'd4;
  localparam logic [CAUSE_W-1:0] CAUSE_ACCESS   = 8'd7;
  localparam logic [3:0] OP_LAST = 4'd8;

  function automatic logic op_unsigned(amo_op_e op);
    return (op == OP_MINU) || (op == OP_MAXU);
  endfunction
endpackage

// File: rtl/amo_operand_ext.sv
module amo_operand_ext #(
  parameter int XLEN = 64
) (
  input  logic            is_word_i,
  input  logic            unsigned_i,
  input  logic [XLEN-1:0] rs2_i,
  input  logic [XLEN-1:0] ld_i,
  output logic [XLEN-1:0] opa_o,
  output logic [XLEN-1:0] opb_o,
  output logic [XLEN-1:0] rd_val_o
);
  localparam int WB = 32;

  always_comb begin
    if (is_word_i) begin
      opa_o    = unsigned_i ? XLEN'(rs2_i[WB-1:0]) : XLEN'($signed(rs2_i[WB-1:0]));
      opb_o    = unsigned_i ? XLEN'(ld_i[WB-1:0])  : XLEN'($signed(ld_i[WB-1:0]));
      // destination is sign-extended regardless of op
      rd_val_o = XLEN'($signed(ld_i[WB-1:0]));
    end else begin
      opa_o    = rs2_i;
      opb_o    = ld_i;
      rd_val_o = ld_i;
    end
  end
endmodule

// File: rtl/amo_alu.sv
module amo_alu
  import amo_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  amo_op_e         op_i,
  input  logic [XLEN-1:0] opa_i,
  input  logic [XLEN-1:0] opb_i,
  output logic [XLEN-1:0] res_o
);
  logic slt, ult;

  assign slt = $signed(opa_i) < $signed(opb_i);
  assign ult = opa_i < opb_i;

  always_comb begin
    unique case (op_i)
      OP_SWAP: res_o = opa_i;
      OP_ADD:  res_o = opa_i + opb_i;
      OP_XOR:  res_o = opa_i ^ opb_i;
      OP_AND:  res_o = opa_i & opb_i;
      OP_OR:   res_o = opa_i | opb_i;
      OP_MIN:  res_o = slt ? opa_i : opb_i;
      OP_MAX:  res_o = slt ? opb_i : opa_i;
      OP_MINU: res_o = ult ? opa_i : opb_i;
      OP_MAXU: res_o = ult ? opb_i : opa_i;
      default: res_o = opa_i;
    endcase
  end
endmodule

// File: rtl/amo_unit.sv
module amo_unit
  import amo_pkg::*;
#(
  parameter int XLEN = 64,
  parameter int AW   = 64
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [3:0]         op_i,
  input  logic [1:0]         width_i,
  input  logic [AW-1:0]      addr_i,
  input  logic [XLEN-1:0]    rs2_i,
  input  logic               aq_i,
  input  logic               rl_i,
  output logic               mem_req_o,
  output logic               mem_we_o,
  output logic [AW-1:0]      mem_addr_o,
  output logic [1:0]         mem_size_o,
  output logic [XLEN-1:0]    mem_wdata_o,
  output logic               mem_aq_o,
  output logic               mem_rl_o,
  input  logic               mem_rvalid_i,
  input  logic [XLEN-1:0]    mem_rdata_i,
  input  logic               mem_err_i,
  output logic               done_o,
  output logic               fault_o,
  output logic [CAUSE_W-1:0] cause_o,
  output logic               rd_we_o,
  output logic [XLEN-1:0]    rd_data_o
);
  localparam int  WB      = 32;
  localparam bit  DW_OK   = (XLEN == 64);

  amo_state_e           state_q, state_d;
  amo_op_e              op_q;
  amo_size_e            size_q;
  logic [AW-1:0]        addr_q;
  logic [XLEN-1:0]      rs2_q, ld_q;
  logic                 aq_q, rl_q;
  logic [CAUSE_W-1:0]   cause_q, cause_d;

  logic                 size_ok, op_ok, align_ok, is_word;
  logic [XLEN-1:0]      opa, opb, rd_val, alu_res;

  assign size_ok  = (width_i == SZ_W) || (DW_OK && width_i == SZ_D);
  assign op_ok    = op_i <= OP_LAST;
  assign align_ok = (width_i == SZ_W) ? (addr_i[1:0] == 2'b00) : (addr_i[2:0] == 3'b000);
  assign is_word  = (size_q == SZ_W);

  always_comb begin
    state_d = state_q;
    cause_d = cause_q;
    unique case (state_q)
      ST_IDLE:
        if (start_i) begin
          if (!size_ok || !op_ok) begin
            state_d = ST_FAULT; cause_d = CAUSE_ILLEGAL;
          end else if (!align_ok) begin
            state_d = ST_FAULT; cause_d = CAUSE_MISALIGN;
          end else begin
            state_d = ST_READ;  cause_d = CAUSE_NONE;
          end
        end
      ST_READ:
        if (mem_rvalid_i) begin
          state_d = mem_err_i ? ST_FAULT : ST_WRITE;
          if (mem_err_i) cause_d = CAUSE_ACCESS;
        end
      ST_WRITE:
        if (mem_rvalid_i) begin
          state_d = mem_err_i ? ST_FAULT : ST_DONE;
          if (mem_err_i) cause_d = CAUSE_ACCESS;
        end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cause_q <= CAUSE_NONE;
      op_q    <= OP_SWAP;
      size_q  <= SZ_W;
      addr_q  <= '0;
      rs2_q   <= '0;
      aq_q    <= 1'b0;
      rl_q    <= 1'b0;
      ld_q    <= '0;
    end else begin
      state_q <= state_d;
      cause_q <= cause_d;
      if (state_q == ST_IDLE && start_i) begin
        op_q   <= amo_op_e'(op_i);
        size_q <= amo_size_e'(width_i);
        addr_q <= addr_i;
        rs2_q  <= rs2_i;
        aq_q   <= aq_i;
        rl_q   <= rl_i;
      end
      if (state_q == ST_READ && mem_rvalid_i && !mem_err_i) ld_q <= mem_rdata_i;
    end
  end

  amo_operand_ext #(.XLEN(XLEN)) u_ext (
    .is_word_i (is_word),
    .unsigned_i(op_unsigned(op_q)),
    .rs2_i     (rs2_q),
    .ld_i      (ld_q),
    .opa_o     (opa),
    .opb_o     (opb),
    .rd_val_o  (rd_val)
  );

  amo_alu #(.XLEN(XLEN)) u_alu (
    .op_i (op_q),
    .opa_i(opa),
    .opb_i(opb),
    .res_o(alu_res)
  );

  assign mem_req_o   = (state_q == ST_READ) || (state_q == ST_WRITE);
  assign mem_we_o    = (state_q == ST_WRITE);
  assign mem_addr_o  = addr_q;
  assign mem_size_o  = size_q;
  assign mem_wdata_o = is_word ? XLEN'(alu_res[WB-1:0]) : alu_res;
  // read: aq / aq&rl ; write: aq&rl / rl
  assign mem_aq_o    = (state_q == ST_READ) ? aq_q : (mem_we_o & aq_q & rl_q);
  assign mem_rl_o    = (state_q == ST_READ) ? (aq_q & rl_q) : (mem_we_o & rl_q);

  assign done_o    = (state_q == ST_DONE) || (state_q == ST_FAULT);
  assign fault_o   = (state_q == ST_FAULT);
  assign cause_o   = fault_o ? cause_q : CAUSE_NONE;
  assign rd_we_o   = (state_q == ST_DONE);
  assign rd_data_o = rd_we_o ? rd_val : '0;

  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R8
  rd_fault_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_we_o |-> (done_o && !fault_o && $past(mem_we_o && mem_rvalid_i && !mem_err_i)));

  // R5
  req_aligned_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> ((mem_size_o == SZ_W && mem_addr_o[1:0] == 2'b00) ||
                   (mem_size_o == SZ_D && mem_addr_o[2:0] == 3'b000)));

  // R3
  word_wdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_size_o == SZ_W) |-> ((mem_wdata_o >> WB) == '0));

  // R4
  rd_sext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_we_o && size_q == SZ_W) |->
      (rd_data_o[XLEN-1:WB-1] == '0 || rd_data_o[XLEN-1:WB-1] == '1));

  // R7
  write_after_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && !$past(mem_we_o)) |-> $past(mem_rvalid_i && !mem_err_i));

  // R9
  wr_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && mem_aq_o) |-> mem_rl_o);

  // R9
  rd_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_rl_o) |-> mem_aq_o);
endmodule

// File: tb/amo_unit_bench.sv
module amo_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  op = '0;
  logic [1:0]  width = 2'd2;
  logic [63:0] addr = '0, rs2 = '0;
  logic        aq = 1'b0, rl = 1'b0;
  logic        mem_req, mem_we, mem_aq, mem_rl;
  logic [63:0] mem_addr, mem_wdata;
  logic [1:0]  mem_size;
  logic        mem_rvalid = 1'b0, mem_err = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic        done, fault, rd_we;
  logic [7:0]  cause;
  logic [63:0] rd_data;

  int tests = 0, fails = 0;
  int req_cnt = 0, wr_cnt = 0;
  bit inj_rd = 0, inj_wr = 0;
  logic [63:0] mem [16];

  always #4 clk = ~clk;

  amo_unit u_amo_unit (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .width_i(width),
    .addr_i(addr), .rs2_i(rs2), .aq_i(aq), .rl_i(rl),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr), .mem_size_o(mem_size),
    .mem_wdata_o(mem_wdata), .mem_aq_o(mem_aq), .mem_rl_o(mem_rl),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .mem_err_i(mem_err),
    .done_o(done), .fault_o(fault), .cause_o(cause), .rd_we_o(rd_we), .rd_data_o(rd_data)
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: answers every request in the following cycle
  always @(negedge clk) begin
    mem_rvalid = mem_req;
    mem_err    = 1'b0;
    if (mem_req) begin
      automatic int idx = int'(mem_addr[6:3]);
      automatic bit hi  = mem_addr[2];
      req_cnt++;
      if (!mem_we) begin
        chk(mem_aq == aq && mem_rl == (aq & rl), "R9 read flags", {mem_aq, mem_rl}, {aq, aq & rl});
        mem_err = inj_rd;
        if (mem_size == 2'd3) mem_rdata = mem[idx];
        else mem_rdata = {32'hA5A5_5A5A, hi ? mem[idx][63:32] : mem[idx][31:0]};
      end else begin
        chk(mem_aq == (aq & rl) && mem_rl == rl, "R9 write flags", {mem_aq, mem_rl}, {aq & rl, rl});
        mem_err = inj_wr;
        if (!inj_wr) begin
          wr_cnt++;
          if (mem_size == 2'd3) mem[idx] = mem_wdata;
          else if (hi) mem[idx][63:32] = mem_wdata[31:0];
          else mem[idx][31:0] = mem_wdata[31:0];
        end
      end
    end
  end

  function automatic logic [63:0] ext32(input logic [31:0] v, input bit zx);
    return zx ? {32'h0, v} : {{32{v[31]}}, v};
  endfunction

  function automatic logic [63:0] model(input int o, input logic [63:0] a, input logic [63:0] b);
    case (o)
      0: return a;
      1: return a + b;
      2: return a ^ b;
      3: return a & b;
      4: return a | b;
      5: return ($signed(a) < $signed(b)) ? a : b;
      6: return ($signed(a) < $signed(b)) ? b : a;
      7: return (a < b) ? a : b;
      default: return (a < b) ? b : a;
    endcase
  endfunction

  // issue one op; returns latency in cycles and sampled outputs
  task automatic run(input int o, input int w, input logic [63:0] ad, input logic [63:0] r,
                     input bit a_q, input bit r_l, output int lat);
    @(negedge clk);
    op = 4'(o); width = 2'(w); addr = ad; rs2 = r; aq = a_q; rl = r_l; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  task automatic after_pulse();
    @(negedge clk);
    chk(!done, "R10 pulse width", 64'(done), 64'd0);
  endtask

  logic [63:0] vals [6];

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int lat;
    vals[0] = 64'h0;                   vals[1] = 64'h1;
    vals[2] = 64'hFFFF_FFFF_FFFF_FFFF; vals[3] = 64'h0000_0000_8000_0000;
    vals[4] = 64'h7FFF_FFFF_7FFF_FFFF; vals[5] = 64'h1234_5678_9ABC_DEF0;
    for (int k = 0; k < 16; k++) mem[k] = 64'h0;

    repeat (3) @(negedge clk);
    // R11
    chk(!done && !fault && !rd_we && !mem_req, "R11 reset outputs",
        {60'h0, done, fault, rd_we, mem_req}, 64'h0);
    rst_n = 1'b1;

    // main sweep: every op, both widths, operand pairs
    for (int o = 0; o < 9; o++) begin
      for (int w = 2; w < 4; w++) begin
        for (int i = 0; i < 6; i++) begin
          for (int j = 0; j < 6; j++) begin
            automatic int  slot = (i * 6 + j) % 16;
            automatic bit  hi   = (w == 2) && (((i + j) % 2) == 1);
            automatic logic [63:0] init = vals[j] ^ {vals[(j + 1) % 6][31:0], vals[(j + 3) % 6][31:0]};
            automatic logic [63:0] ld, a, b, res, exp_mem, exp_rd;
            automatic bit zx = (o == 7) || (o == 8);
            mem[slot] = init;
            if (w == 3) begin
              ld = init; a = vals[i]; b = ld;
              res = model(o, a, b); exp_mem = res; exp_rd = ld;
            end else begin
              ld = hi ? {32'h0, init[63:32]} : {32'h0, init[31:0]};
              a = ext32(vals[i][31:0], zx); b = ext32(ld[31:0], zx);
              res = model(o, a, b);
              exp_mem = hi ? {res[31:0], init[31:0]} : {init[63:32], res[31:0]};
              exp_rd = ext32(ld[31:0], 1'b0);
            end
            run(o, w, 64'(slot * 8 + (hi ? 4 : 0)), vals[i], i[0], j[0], lat);
            // R1 R2 R3: memory result and untouched half
            chk(mem[slot] == exp_mem, (w == 2) ? "R2 R3 word result" : "R1 dword result", mem[slot], exp_mem);
            // R4
            chk(rd_we && !fault && rd_data == exp_rd, "R4 rd value", rd_data, exp_rd);
            // R10
            chk(lat == 3, "R10 latency", 64'(lat), 64'd3);
            after_pulse();
          end
        end
      end
    end

    // R5: misaligned
    for (int w = 2; w < 4; w++) begin
      for (int off = 1; off < (w == 2 ? 4 : 8); off++) begin
        automatic int rc = req_cnt;
        run(1, w, 64'(32 + off), 64'h5, 1'b0, 1'b0, lat);
        chk(fault && cause == 8'd4 && !rd_we, "R5 misaligned cause", 64'(cause), 64'd4);
        chk(lat == 1 && req_cnt == rc, "R5 no request", 64'(req_cnt - rc), 64'd0);
        after_pulse();
      end
    end

    // R6: undefined widths and opcodes
    for (int w = 0; w < 2; w++) begin
      automatic int rc = req_cnt;
      run(0, w, 64'h40, 64'h1, 1'b0, 1'b0, lat);
      chk(fault && cause == 8'd2 && lat == 1 && req_cnt == rc, "R6 bad width", 64'(cause), 64'd2);
      after_pulse();
    end
    for (int o = 9; o < 16; o++) begin
      automatic int rc = req_cnt;
      run(o, 3, 64'h40, 64'h1, 1'b0, 1'b0, lat);
      chk(fault && cause == 8'd2 && lat == 1 && req_cnt == rc, "R6 bad opcode", 64'(cause), 64'd2);
      after_pulse();
    end

    // R7: read error
    for (int w = 2; w < 4; w++) begin
      automatic int wc = wr_cnt;
      mem[3] = 64'hCAFE_F00D_0BAD_BEEF;
      inj_rd = 1;
      run(1, w, 64'h18, 64'h1, 1'b1, 1'b1, lat);
      inj_rd = 0;
      chk(fault && cause == 8'd7 && !rd_we && lat == 2, "R7 read error cause", 64'(cause), 64'd7);
      chk(wr_cnt == wc && mem[3] == 64'hCAFE_F00D_0BAD_BEEF, "R7 no write", mem[3], 64'hCAFE_F00D_0BAD_BEEF);
      after_pulse();
    end

    // R8: write error
    for (int w = 2; w < 4; w++) begin
      mem[4] = 64'h0123_4567_89AB_CDEF;
      inj_wr = 1;
      run(0, w, 64'h20, 64'hFFFF, 1'b0, 1'b1, lat);
      inj_wr = 0;
      chk(fault && cause == 8'd7 && lat == 3, "R8 write error cause", 64'(cause), 64'd7);
      chk(!rd_we && rd_data == 64'h0, "R8 no rd write", 64'(rd_we), 64'd0);
      chk(mem[4] == 64'h0123_4567_89AB_CDEF, "R8 memory kept", mem[4], 64'h0123_4567_89AB_CDEF);
      after_pulse();
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule